// File: doc/BRIEF.md
# Dual-Input Up/Down Event Counter

This block counts events on two separate active-low pulse lines per channel. Each channel has one line that steps the count up and one that steps it down. Each channel also has an active-low clear line. Every channel keeps an unsigned count of `WIDTH` bits (24 by default). All channels are presented side by side on one flat parallel output, which a host register map samples. All channels share a single system clock. The pulse lines are assumed to be asynchronous and much slower than that clock.

Every pulse and clear line is first brought into the clock domain through a two-flop synchroniser. A falling edge on a pulse line is then turned into a one-cycle event. Per channel, a small arbiter reduces the clear level and the two events to one of four actions: hold, step up, step down or zero. The count register then applies that action with modular arithmetic, so it wraps in both directions. No value other than zero can ever be loaded.

Top module: `updn_event_counter`

## Requirements
- R1: While `rst_ni` is low, every channel's count is 0.
- R2: Each high-to-low transition on a channel's `up_ni` bit adds exactly one to that channel's count. The line staying low adds nothing more.
- R3: Each high-to-low transition on a channel's `down_ni` bit subtracts exactly one from that channel's count.
- R4: While a channel's `clr_ni` bit is low, its count reads 0. Pulses arriving during that time are discarded and are not counted after release.
- R5: A clear and a pulse edge that reach the arbiter in the same cycle produce 0, never the stepped value.
- R6: An up edge and a down edge that reach the arbiter in the same cycle leave the count unchanged.
- R7: Counting up from all-ones (0xFFFFFF at the default width) gives 0.
- R8: Counting down from 0 gives all-ones (0xFFFFFF at the default width).
- R9: Channel n occupies `count_o[n*WIDTH +: WIDTH]` and responds only to bit n of `up_ni`, `down_ni` and `clr_ni`.
- R10: If an input edge is first sampled at clock edge k, the count still shows the old value after edges k and k+1, and shows the new value after edge k+2.
- R11: Rising transitions on `up_ni` or `down_ni` leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_ni | input | N_CH | Per-channel count-up pulse, falling edge active |
| down_ni | input | N_CH | Per-channel count-down pulse, falling edge active |
| clr_ni | input | N_CH | Per-channel clear, active low, level sensitive |
| count_o | output | N_CH*WIDTH | Concatenated channel counts, channel 0 in the low bits |

## Verification
The bench drives the default design and a second instance only 4 bits wide from the same inputs. Long pulse trains make the narrow counter wrap many times in both directions, and the wide counter is taken through 0 to all-ones and back. Each pulse is checked twice: while its line is still low and again after it rises. A design that counted levels or rising edges would drift at the second check. The latency check fails if a stage is missing or added. Coincident up/down edges expose a design that lets one direction win. Clear asserted together with an up edge, on a non-zero count, catches a design where the edge wins. Pulses issued while clear is held catch a design that remembers them and counts them after release.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_ZERO = 2'd3
  } step_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o
);
  // Lines idle high, so the chain resets to 1.
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= 1'b1;
        else         chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/updn_fall_det.sv
module updn_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= level_i;
  end

  assign fall_o = last_q & ~level_i;

  p_fall_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/updn_step_sel.sv
module updn_step_sel
  import updn_pkg::*;
(
  input  logic  clr_ni,
  input  logic  up_fall_i,
  input  logic  down_fall_i,
  output step_e step_o
);
  always_comb begin
    if (!clr_ni)                    step_o = STEP_ZERO;
    else if (up_fall_i == down_fall_i) step_o = STEP_HOLD;
    else if (up_fall_i)             step_o = STEP_INC;
    else                            step_o = STEP_DEC;
  end
endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      unique case (step_i)
        STEP_ZERO: count_q <= '0;
        STEP_INC:  count_q <= count_q + ONE;
        STEP_DEC:  count_q <= count_q - ONE;
        default:   count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/updn_channel.sv
module updn_channel
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_ni,
  input  logic             down_ni,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] count_o
);
  logic  up_lvl, down_lvl, clr_lvl;
  logic  up_fall, down_fall;
  step_e step;

  updn_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(up_ni), .level_o(up_lvl));
  updn_sync #(.STAGES(SYNC_STAGES)) u_sync_down (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(down_ni), .level_o(down_lvl));
  updn_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(clr_ni), .level_o(clr_lvl));

  updn_fall_det u_fall_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(up_lvl), .fall_o(up_fall));
  updn_fall_det u_fall_down (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(down_lvl), .fall_o(down_fall));

  updn_step_sel u_sel (
    .clr_ni(clr_lvl), .up_fall_i(up_fall), .down_fall_i(down_fall), .step_o(step));

  updn_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .count_o(count_o));

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_lvl |=> (count_o == '0));
  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lvl && up_fall && !down_fall) |=> ((count_o - $past(count_o)) == WIDTH'(1)));
  p_down_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lvl && down_fall && !up_fall) |=> (($past(count_o) - count_o) == WIDTH'(1)));
  p_both_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lvl && up_fall && down_fall) |=> $stable(count_o));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lvl && !up_fall && !down_fall) |=> $stable(count_o));
endmodule

// File: rtl/updn_event_counter.sv
module updn_event_counter #(
  parameter int unsigned N_CH        = 2,
  parameter int unsigned WIDTH       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       up_ni,
  input  logic [N_CH-1:0]       down_ni,
  input  logic [N_CH-1:0]       clr_ni,
  output logic [N_CH*WIDTH-1:0] count_o
);
  genvar ch;
  generate
    for (ch = 0; ch < N_CH; ch++) begin : g_ch
      updn_channel #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .up_ni  (up_ni[ch]),
        .down_ni(down_ni[ch]),
        .clr_ni (clr_ni[ch]),
        .count_o(count_o[ch*WIDTH +: WIDTH])
      );
    end
  endgenerate

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> (count_o == '0));
endmodule

// File: tb/updn_event_counter_tb_top.sv
`timescale 1ns/1ps
module updn_event_counter_tb_top;
  localparam int CLK_PERIOD = 250;
  localparam int W  = 24;
  localparam int WS = 4;
  localparam int NC = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] up_n = '1, down_n = '1, clr_n = '1;
  logic [NC*W-1:0]  cnt;
  logic [NC*WS-1:0] cnt_s;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_c [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_event_counter #(.N_CH(NC), .WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .up_ni(up_n), .down_ni(down_n),
    .clr_ni(clr_n), .count_o(cnt));

  updn_event_counter #(.N_CH(NC), .WIDTH(WS)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .up_ni(up_n), .down_ni(down_n),
    .clr_ni(clr_n), .count_o(cnt_s));

  task automatic check(input string req, input int ch, input logic [W-1:0] exp);
    logic [W-1:0]  act   = cnt[ch*W +: W];
    logic [WS-1:0] act_s = cnt_s[ch*WS +: WS];
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s ch%0d wide: actual %h expected %h", req, ch, act, exp);
    end
    vectors++;
    if (act_s !== exp[WS-1:0]) begin
      miscompares++;
      $display("FAIL %s ch%0d narrow: actual %h expected %h", req, ch, act_s, exp[WS-1:0]);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NC; c++) check(req, c, exp_c[c]);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One pulse: count must move while low (R2/R3) and not again on release (R11).
  task automatic pulse(input int ch, input bit up, input bit dn, input string req);
    @(negedge clk);
    if (up) up_n[ch] = 1'b0;
    if (dn) down_n[ch] = 1'b0;
    if (up && !dn) exp_c[ch] = exp_c[ch] + 1'b1;
    if (dn && !up) exp_c[ch] = exp_c[ch] - 1'b1;
    wait_n(4);
    check_all(req);
    up_n[ch] = 1'b1;
    down_n[ch] = 1'b1;
    wait_n(4);
    check_all("R11");
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    miscompares++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) exp_c[c] = '0;
    wait_n(3);
    check_all("R1");
    // R1: edges under reset are not counted
    up_n[0] = 1'b0;
    wait_n(3);
    check_all("R1");
    up_n[0] = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    check_all("R1");

    // R10: exact latency of an up edge on channel 0
    @(negedge clk);
    up_n[0] = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", 0, 24'h0);
    @(posedge clk); @(negedge clk);
    check("R10", 0, 24'h0);
    @(posedge clk); @(negedge clk);
    exp_c[0] = 24'h1;
    check("R10", 0, exp_c[0]);
    // R2: holding the line low adds nothing more
    wait_n(6);
    check("R2", 0, exp_c[0]);
    up_n[0] = 1'b1;
    wait_n(4);
    check_all("R11");

    // R8: down from zero on channel 1 wraps to all-ones; channel 0 untouched (R9)
    pulse(1, 1'b0, 1'b1, "R8");
    check("R9", 0, 24'h1);
    // R7: up from all-ones wraps to zero
    pulse(1, 1'b1, 1'b0, "R7");

    // R3 and narrow-width wrap sweep: 20 downs then 40 ups on channel 0
    for (int i = 0; i < 20; i++) pulse(0, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 40; i++) pulse(0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 5; i++) pulse(1, 1'b1, 1'b0, "R9");

    // R6: coincident up and down edges hold
    for (int c = 0; c < NC; c++) pulse(c, 1'b1, 1'b1, "R6");

    // R5: clear with a coincident up edge on a non-zero count gives zero at the step edge
    @(negedge clk);
    clr_n[0] = 1'b0;
    up_n[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    exp_c[0] = '0;
    check("R5", 0, exp_c[0]);
    check("R9", 1, exp_c[1]);
    up_n[0] = 1'b1;
    wait_n(3);

    // R4: pulses during clear are discarded, also after release
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); up_n[0] = 1'b0; wait_n(3);
      check("R4", 0, 24'h0);
      up_n[0] = 1'b1; wait_n(3);
      check("R4", 0, 24'h0);
    end
    down_n[0] = 1'b0;
    wait_n(4);
    clr_n[0] = 1'b1;
    wait_n(6);
    check("R4", 0, 24'h0);
    down_n[0] = 1'b1;
    wait_n(4);
    check("R4", 0, 24'h0);
    pulse(0, 1'b1, 1'b0, "R4");

    // R4: clear on channel 1 does not touch channel 0 (R9)
    @(negedge clk);
    clr_n[1] = 1'b0;
    wait_n(4);
    exp_c[1] = '0;
    check_all("R9");
    clr_n[1] = 1'b1;
    wait_n(4);
    pulse(1, 1'b0, 1'b1, "R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule